// File: doc/BRIEF.md
# Multi-host mailbox ownership controller

This block arbitrates ownership of a small set of input/output mailbox pairs that are shared by up to eight bus hosts. Every access presents a 3-bit host identifier and a protection flag. A host claims a mailbox by linking to it. It hands a token to the internal controller by marking the input full, and it releases a result by marking the output empty once it has read it. A single master host (ID 0) has a separate force path that can strip ownership from a mailbox or discard its pending result. Per mailbox, an 8-bit lockout map can shut out chosen hosts.

On the internal side, the controller consumes input tokens and posts results, and each result is tagged with the host that may collect it. Status is combinational and computed for the host currently presented on the access port. Any host sees whether a mailbox is taken and whether it is full, but only the owner sees its own "linked" bit. Mailbox data storage is not part of this block.

Top module: `mbx_own_ctrl`

## Requirements
- R1: After reset every mailbox is unlinked with input and output empty, all status, link-ID and output-ID bits read 0, and each mailbox's 8-bit lockout map reads 0x0E (hosts 1, 2 and 3 blocked).
- R2: A command access (`acc_kind`=1) with the link bit (nibble bit 2) set links the mailbox to the requesting host only if the input is not full and the mailbox is unlinked or already linked to that host. On success, the link-ID field becomes {protection flag of the access, host ID bits 1:0}.
- R3: The unlink bit (nibble bit 3) releases the mailbox only when it comes from the current owner, and it clears the link-ID field. When the link and unlink bits are set in one write, the link bit is ignored. The link-ID field never changes in a cycle without an access.
- R4: The in-full bit (nibble bit 0) sets input-full only when written by the current owner. `core_take` clears input-full, except when a valid in-full command arrives in the same cycle, in which case input-full stays set.
- R5: `core_post` sets output-full and latches {`core_dest_prot`, `core_dest[1:0]`} into the output-ID field. The out-empty bit (nibble bit 1) clears output-full only when written by the posted destination host. A post wins over an empty in the same cycle.
- R6: A force access (`acc_kind`=2) from host 0 unlinks the mailbox (nibble bit 3) and/or clears output-full (nibble bit 1), whoever owns the mailbox. A force access from any other host has no effect.
- R7: A lockout write (`acc_kind`=3) from host 0 loads `acc_data[8i+7:8i]` as mailbox i's lockout map. Such writes from other hosts are ignored. Commands and force accesses from a host whose lockout bit is set have no effect on that mailbox.
- R8: A mailbox linked through a protected access accepts link, unlink and in-full commands only from protected accesses. A result posted with `core_dest_prot`=1 can be emptied only by a protected access.
- R9: Status nibble i (bits 4i+3:4i) holds {available, linked-to-viewer, output-full, input-full}. Available is set when the mailbox is linked to any host or its input is full. Linked-to-viewer is set only when `acc_host` is the owner.
- R10: Command bits for mailbox i sit at `acc_data[4i+3:4i]`, and the mailboxes change state independently of each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_valid | input | 1 | Host access strobe |
| acc_kind | input | 2 | 0 status view, 1 command, 2 master force, 3 lockout write |
| acc_host | input | 3 | Requesting or viewing host ID |
| acc_prot | input | 1 | Access is protected |
| acc_data | input | 16 | Command nibbles (bits 4i+3:4i) or lockout maps (bits 8i+7:8i) |
| core_take | input | 2 | Internal side consumed mailbox i's input token |
| core_post | input | 2 | Internal side posts a result to mailbox i |
| core_dest | input | 3 | Destination host of a posted result |
| core_dest_prot | input | 1 | Posted result needs protected access |
| status_o | output | 8 | Viewer-relative status nibbles |
| link_id_o | output | 6 | Per mailbox {protected-only, owner ID[1:0]} |
| out_id_o | output | 6 | Per mailbox {protected-only, destination ID[1:0]} |
| lockout_o | output | 16 | Per mailbox host lockout maps |
| in_full_o | output | 2 | Input-full flags for the internal side |

## Verification
The assertions assume that `core_post` and `core_take` are not raised together for one mailbox in a way the internal side would not produce. They also assume that `acc_kind` carries one of its four encodings on every cycle in which `acc_valid` is high. The stimulus drives every input from bench registers that change only just after the falling edge. It pairs directed sequences for each ownership rule with a long random phase. In that phase, lockout writes are rare and use sparse bit patterns, so most commands still reach their mailbox while the blocked paths are still exercised.

// File: rtl/mbx_own_pkg.sv
// Shared encodings for the mailbox ownership controller.
// Assumes: four command bits and four status bits per mailbox.
package mbx_own_pkg;
    typedef enum logic [1:0] {
        ACC_VIEW  = 2'd0,
        ACC_CMD   = 2'd1,
        ACC_FORCE = 2'd2,
        ACC_LOCK  = 2'd3
    } acc_kind_e;

    localparam int NIB_W         = 4;
    localparam int CMD_IN_FULL   = 0;
    localparam int CMD_OUT_EMPTY = 1;
    localparam int CMD_LINK      = 2;
    localparam int CMD_UNLINK    = 3;

    localparam int ST_IN_FULL  = 0;
    localparam int ST_OUT_FULL = 1;
    localparam int ST_MINE     = 2;
    localparam int ST_AVAIL    = 3;
endpackage

// File: rtl/mbx_gate.sv
// Access filter for one mailbox: applies the host lockout map, the
// protected-only guards and the master-only rule for force accesses.
// Assumes: guard inputs come from registered mailbox state.
module mbx_gate #(
    parameter int HOST_W    = 3,
    parameter int MASTER_ID = 0,
    localparam int HOSTS    = 1 << HOST_W
) (
    input  logic [HOSTS-1:0]  lock_map,
    input  logic [HOST_W-1:0] host,
    input  logic              prot,
    input  logic              cmd_req,
    input  logic              force_req,
    input  logic              guard_in,
    input  logic              guard_out,
    output logic              cmd_in_ok,
    output logic              cmd_out_ok,
    output logic              force_ok
);
    logic blocked;

    // Derive which request classes may touch this mailbox.
    always_comb begin
        blocked    = lock_map[host];
        cmd_in_ok  = cmd_req && !blocked && (!guard_in || prot);
        cmd_out_ok = cmd_req && !blocked && (!guard_out || prot);
        force_ok   = force_req && !blocked && (host == HOST_W'(MASTER_ID));
    end
endmodule

// File: rtl/mbx_slot.sv
// Ownership and full/empty state of one input/output mailbox pair.
// Assumes: gate qualifiers are already filtered for lockout and protection.
module mbx_slot
    import mbx_own_pkg::*;
#(
    parameter int HOST_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [HOST_W-1:0] host,
    input  logic              prot,
    input  logic [NIB_W-1:0]  nib,
    input  logic              cmd_in_ok,
    input  logic              cmd_out_ok,
    input  logic              force_ok,
    input  logic              take,
    input  logic              post,
    input  logic [HOST_W-1:0] dest,
    input  logic              dest_prot,
    output logic              linked,
    output logic [HOST_W-1:0] owner,
    output logic              link_prot,
    output logic              in_full,
    output logic              out_full,
    output logic [HOST_W-1:0] out_dest,
    output logic              out_prot
);
    logic is_owner, do_unlink, do_link, do_fill, do_empty;

    // Decode the effective actions from the pre-write state.
    always_comb begin
        is_owner  = linked && (owner == host);
        do_unlink = (cmd_in_ok && nib[CMD_UNLINK] && is_owner)
                  || (force_ok && nib[CMD_UNLINK]);
        do_link   = cmd_in_ok && nib[CMD_LINK] && !nib[CMD_UNLINK] && !in_full
                  && (!linked || owner == host);
        do_fill   = cmd_in_ok && nib[CMD_IN_FULL] && is_owner;
        do_empty  = (cmd_out_ok && nib[CMD_OUT_EMPTY] && out_full && out_dest == host)
                  || (force_ok && nib[CMD_OUT_EMPTY]);
    end

    // Ownership register: unlink has priority over link.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            linked    <= 1'b0;
            owner     <= '0;
            link_prot <= 1'b0;
        end else if (do_unlink) begin
            linked    <= 1'b0;
            owner     <= '0;
            link_prot <= 1'b0;
        end else if (do_link) begin
            linked    <= 1'b1;
            owner     <= host;
            link_prot <= prot;
        end
    end

    // Input-full flag: a host fill wins over a consume in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)       in_full <= 1'b0;
        else if (do_fill) in_full <= 1'b1;
        else if (take)    in_full <= 1'b0;
    end

    // Output-full flag and destination tag: a post wins over an empty.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_full <= 1'b0;
            out_dest <= '0;
            out_prot <= 1'b0;
        end else if (post) begin
            out_full <= 1'b1;
            out_dest <= dest;
            out_prot <= dest_prot;
        end else if (do_empty) begin
            out_full <= 1'b0;
        end
    end
endmodule

// File: rtl/mbx_lock_reg.sv
// Per-mailbox host lockout maps, writable only by the master host.
// Assumes: one lockout map of 2**HOST_W bits per mailbox.
module mbx_lock_reg #(
    parameter int          NUM_MBX   = 2,
    parameter int          HOST_W    = 3,
    parameter int          MASTER_ID = 0,
    parameter logic [7:0]  LOCK_INIT = 8'h0E,
    localparam int         HOSTS     = 1 << HOST_W,
    localparam int         MAP_W     = NUM_MBX * HOSTS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_req,
    input  logic [HOST_W-1:0] host,
    input  logic [MAP_W-1:0]  wdata,
    output logic [MAP_W-1:0]  maps
);
    // Load all maps on a master write; reset to the default blocking pattern.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_MBX; i++) maps[i*HOSTS +: HOSTS] <= HOSTS'(LOCK_INIT);
        end else if (wr_req && host == HOST_W'(MASTER_ID)) begin
            maps <= wdata;
        end
    end
endmodule

// File: rtl/mbx_own_ctrl.sv
// Top of the multi-host mailbox ownership controller: one gate and one
// slot per mailbox, a shared lockout register and viewer-relative status.
// Assumes: one host access per cycle; status follows acc_host combinationally.
module mbx_own_ctrl
    import mbx_own_pkg::*;
#(
    parameter int NUM_MBX   = 2,
    parameter int HOST_W    = 3,
    parameter int MASTER_ID = 0,
    parameter int ID_SHOW   = 2,
    localparam int HOSTS    = 1 << HOST_W,
    localparam int DATA_W   = NUM_MBX * HOSTS,
    localparam int TAG_W    = ID_SHOW + 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      acc_valid,
    input  logic [1:0]                acc_kind,
    input  logic [HOST_W-1:0]         acc_host,
    input  logic                      acc_prot,
    input  logic [DATA_W-1:0]         acc_data,
    input  logic [NUM_MBX-1:0]        core_take,
    input  logic [NUM_MBX-1:0]        core_post,
    input  logic [HOST_W-1:0]         core_dest,
    input  logic                      core_dest_prot,
    output logic [NIB_W*NUM_MBX-1:0]  status_o,
    output logic [TAG_W*NUM_MBX-1:0]  link_id_o,
    output logic [TAG_W*NUM_MBX-1:0]  out_id_o,
    output logic [DATA_W-1:0]         lockout_o,
    output logic [NUM_MBX-1:0]        in_full_o
);
    acc_kind_e kind;
    logic      cmd_req, force_req, lock_req;

    // Classify the current access.
    always_comb begin
        kind      = acc_kind_e'(acc_kind);
        cmd_req   = acc_valid && kind == ACC_CMD;
        force_req = acc_valid && kind == ACC_FORCE;
        lock_req  = acc_valid && kind == ACC_LOCK;
    end

    mbx_lock_reg #(
        .NUM_MBX(NUM_MBX), .HOST_W(HOST_W), .MASTER_ID(MASTER_ID)
    ) lock_i (
        .clk(clk), .rst_n(rst_n), .wr_req(lock_req), .host(acc_host),
        .wdata(acc_data), .maps(lockout_o)
    );

    for (genvar g = 0; g < NUM_MBX; g++) begin : g_mbx
        logic              cmd_in_ok, cmd_out_ok, force_ok;
        logic              linked, link_prot, in_full, out_full, out_prot;
        logic [HOST_W-1:0] owner, out_dest;

        mbx_gate #(.HOST_W(HOST_W), .MASTER_ID(MASTER_ID)) gate_i (
            .lock_map(lockout_o[g*HOSTS +: HOSTS]), .host(acc_host), .prot(acc_prot),
            .cmd_req(cmd_req), .force_req(force_req),
            .guard_in(linked && link_prot), .guard_out(out_full && out_prot),
            .cmd_in_ok(cmd_in_ok), .cmd_out_ok(cmd_out_ok), .force_ok(force_ok)
        );

        mbx_slot #(.HOST_W(HOST_W)) slot_i (
            .clk(clk), .rst_n(rst_n), .host(acc_host), .prot(acc_prot),
            .nib(acc_data[g*NIB_W +: NIB_W]),
            .cmd_in_ok(cmd_in_ok), .cmd_out_ok(cmd_out_ok), .force_ok(force_ok),
            .take(core_take[g]), .post(core_post[g]),
            .dest(core_dest), .dest_prot(core_dest_prot),
            .linked(linked), .owner(owner), .link_prot(link_prot),
            .in_full(in_full), .out_full(out_full),
            .out_dest(out_dest), .out_prot(out_prot)
        );

        // Present status as seen by the host on the access port.
        always_comb begin
            status_o[g*NIB_W + ST_IN_FULL]  = in_full;
            status_o[g*NIB_W + ST_OUT_FULL] = out_full;
            status_o[g*NIB_W + ST_MINE]     = linked && (owner == acc_host);
            status_o[g*NIB_W + ST_AVAIL]    = linked || in_full;
            link_id_o[g*TAG_W +: TAG_W]     = {link_prot, owner[ID_SHOW-1:0]};
            out_id_o[g*TAG_W +: TAG_W]      = {out_prot, out_dest[ID_SHOW-1:0]};
            in_full_o[g]                    = in_full;
        end
    end
endmodule

// File: rtl/mbx_own_ctrl_chk.sv
// Property checker for the mailbox ownership controller, bound to the top.
// Assumes: the same parameters as the instance it is bound to.
module mbx_own_ctrl_chk #(
    parameter int NUM_MBX   = 2,
    parameter int HOST_W    = 3,
    parameter int MASTER_ID = 0,
    localparam int HOSTS    = 1 << HOST_W,
    localparam int DATA_W   = NUM_MBX * HOSTS
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   acc_valid,
    input logic [1:0]             acc_kind,
    input logic [HOST_W-1:0]      acc_host,
    input logic [NUM_MBX-1:0]     core_take,
    input logic [NUM_MBX-1:0]     core_post,
    input logic [4*NUM_MBX-1:0]   status_o,
    input logic [3*NUM_MBX-1:0]   link_id_o,
    input logic [DATA_W-1:0]      lockout_o,
    input logic [NUM_MBX-1:0]     in_full_o
);
    // Lockout maps move only on a master lockout write.
    p_lock_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(acc_valid && acc_kind == 2'd3 && acc_host == HOST_W'(MASTER_ID))
        |=> $stable(lockout_o));

    for (genvar g = 0; g < NUM_MBX; g++) begin : g_chk
        // Ownership seen by the viewer implies the mailbox is taken.
        p_mine_avail_r9: assert property (@(posedge clk) disable iff (!rst_n)
            status_o[4*g+2] |-> status_o[4*g+3]);
        // A full input also makes the mailbox unavailable.
        p_full_avail_r4: assert property (@(posedge clk) disable iff (!rst_n)
            in_full_o[g] |-> status_o[4*g+3]);
        // A consume without a concurrent command empties the input.
        p_take_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (core_take[g] && !(acc_valid && acc_kind == 2'd1)) |=> !in_full_o[g]);
        // A posted result is visible as output-full next cycle.
        p_post_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
            core_post[g] |=> status_o[4*g+1]);
        // Without an access the owner tag cannot move.
        p_idle_owner_r3: assert property (@(posedge clk) disable iff (!rst_n)
            !acc_valid |=> $stable(link_id_o[3*g +: 3]));
    end
endmodule

bind mbx_own_ctrl mbx_own_ctrl_chk #(
    .NUM_MBX(NUM_MBX), .HOST_W(HOST_W), .MASTER_ID(MASTER_ID)
) chk_i (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_kind(acc_kind),
    .acc_host(acc_host), .core_take(core_take), .core_post(core_post),
    .status_o(status_o), .link_id_o(link_id_o), .lockout_o(lockout_o),
    .in_full_o(in_full_o)
);

// File: tb/mbx_own_ctrl_tb_top.sv
`timescale 1ns/100ps
module mbx_own_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_valid = 1'b0;
    logic [1:0]  acc_kind = 2'd0;
    logic [2:0]  acc_host = 3'd0;
    logic        acc_prot = 1'b0;
    logic [15:0] acc_data = 16'h0;
    logic [1:0]  core_take = 2'b0;
    logic [1:0]  core_post = 2'b0;
    logic [2:0]  core_dest = 3'd0;
    logic        core_dest_prot = 1'b0;
    logic [7:0]  status_o;
    logic [5:0]  link_id_o, out_id_o;
    logic [15:0] lockout_o;
    logic [1:0]  in_full_o;

    int    vectors = 0;
    int    miscompares = 0;
    bit    chk_on = 1'b0;
    bit    done = 1'b0;
    string cur_req = "R1";

    // Behavioural reference state.
    bit       m_linked[2], m_lprot[2], m_in[2], m_out[2], m_oprot[2];
    int       m_owner[2], m_dest[2];
    bit [7:0] m_lock[2];

    always #2.5 clk = ~clk;

    mbx_own_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_kind(acc_kind),
        .acc_host(acc_host), .acc_prot(acc_prot), .acc_data(acc_data),
        .core_take(core_take), .core_post(core_post), .core_dest(core_dest),
        .core_dest_prot(core_dest_prot), .status_o(status_o), .link_id_o(link_id_o),
        .out_id_o(out_id_o), .lockout_o(lockout_o), .in_full_o(in_full_o)
    );

    // Reference model: update on every rising edge from the applied inputs.
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 2; i++) begin
                m_linked[i] = 0; m_lprot[i] = 0; m_in[i] = 0; m_out[i] = 0;
                m_oprot[i] = 0; m_owner[i] = 0; m_dest[i] = 0; m_lock[i] = 8'h0E;
            end
        end else begin
            int h;
            h = int'(acc_host);
            for (int i = 0; i < 2; i++) begin
                bit blk, cmd, frc, in_ok, out_ok, mine, n_link, n_in, n_out;
                bit [3:0] nb;
                int n_owner;
                bit n_lprot;
                nb     = acc_data[4*i +: 4];
                blk    = m_lock[i][h];
                cmd    = acc_valid && acc_kind == 2'd1 && !blk;
                frc    = acc_valid && acc_kind == 2'd2 && !blk && h == 0;
                in_ok  = cmd && (!(m_linked[i] && m_lprot[i]) || acc_prot);
                out_ok = cmd && (!(m_out[i] && m_oprot[i]) || acc_prot);
                mine   = m_linked[i] && m_owner[i] == h;
                n_link = m_linked[i]; n_owner = m_owner[i]; n_lprot = m_lprot[i];
                if ((in_ok && nb[3] && mine) || (frc && nb[3])) begin
                    n_link = 0; n_owner = 0; n_lprot = 0;
                end else if (in_ok && nb[2] && !nb[3] && !m_in[i] && (!m_linked[i] || m_owner[i] == h)) begin
                    n_link = 1; n_owner = h; n_lprot = acc_prot;
                end
                n_in = m_in[i];
                if (in_ok && nb[0] && mine) n_in = 1;
                else if (core_take[i])      n_in = 0;
                n_out = m_out[i];
                if (core_post[i]) begin
                    n_out = 1; m_dest[i] = int'(core_dest); m_oprot[i] = core_dest_prot;
                end else if ((out_ok && nb[1] && m_out[i] && m_dest[i] == h) || (frc && nb[1])) begin
                    n_out = 0;
                end
                m_linked[i] = n_link; m_owner[i] = n_owner; m_lprot[i] = n_lprot;
                m_in[i] = n_in; m_out[i] = n_out;
            end
            if (acc_valid && acc_kind == 2'd3 && h == 0) begin
                m_lock[0] = acc_data[7:0];
                m_lock[1] = acc_data[15:8];
            end
        end
    end

    task automatic cmp(string what, logic [15:0] act, logic [15:0] exp);
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s %s: actual %h expected %h", cur_req, what, act, exp);
        end
    endtask

    // Compare every output with the model away from the active edge.
    always @(negedge clk) begin
        if (chk_on) begin
            logic [7:0] es;
            logic [5:0] el, eo;
            vectors++;
            for (int i = 0; i < 2; i++) begin
                es[4*i]   = m_in[i];
                es[4*i+1] = m_out[i];
                es[4*i+2] = m_linked[i] && m_owner[i] == int'(acc_host);
                es[4*i+3] = m_linked[i] || m_in[i];
                el[3*i +: 3] = {m_lprot[i], 2'(m_owner[i])};
                eo[3*i +: 3] = {m_oprot[i], 2'(m_dest[i])};
            end
            cmp("status", 16'(status_o), 16'(es));
            cmp("link_id", 16'(link_id_o), 16'(el));
            cmp("out_id", 16'(out_id_o), 16'(eo));
            cmp("lockout", lockout_o, {m_lock[1], m_lock[0]});
            cmp("in_full", 16'(in_full_o), {14'd0, m_in[1], m_in[0]});
        end
    end

    // One clock of stimulus, applied just after the falling edge.
    task automatic step(bit v, bit [1:0] k, bit [2:0] h, bit p, bit [15:0] d,
                        bit [1:0] tk, bit [1:0] ps, bit [2:0] ds, bit dp);
        acc_valid = v; acc_kind = k; acc_host = h; acc_prot = p; acc_data = d;
        core_take = tk; core_post = ps; core_dest = ds; core_dest_prot = dp;
        @(negedge clk); #1;
        acc_valid = 0; acc_kind = 0; acc_data = 0; core_take = 0; core_post = 0;
    endtask
    task automatic acc(bit [1:0] k, bit [2:0] h, bit p, bit [15:0] d);
        step(1, k, h, p, d, 0, 0, 0, 0);
    endtask
    task automatic view(bit [2:0] h);
        step(0, 0, h, 0, 0, 0, 0, 0, 0);
    endtask
    task automatic core(bit [1:0] tk, bit [1:0] ps, bit [2:0] ds, bit dp);
        step(0, 0, 0, 0, 0, tk, ps, ds, dp);
    endtask
    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog: actual hung expected done");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk); #1; chk_on = 1'b1;
        // R1: reset state
        cur_req = "R1";  view(0); view(5);
        // R7: non-master lockout write ignored, then master opens hosts 1..6
        cur_req = "R7";  acc(3, 1, 0, 16'h0000); view(1);
        acc(3, 0, 0, 16'h8080); view(0);
        // R2: link rules
        cur_req = "R2";  acc(1, 0, 0, 16'h0004); view(0); view(4);
        acc(1, 2, 0, 16'h0004); acc(1, 2, 1, 16'h0040); view(2); acc(1, 2, 1, 16'h0040);
        // R3: unlink by non-owner, unlink+link together
        cur_req = "R3";  acc(1, 4, 0, 16'h0008); view(0);
        acc(1, 0, 0, 16'h000C); view(0); acc(1, 3, 0, 16'h0004); view(3);
        // R8: protected-only mailbox 1 (owner 2)
        cur_req = "R8";  acc(1, 2, 0, 16'h0080); acc(1, 2, 0, 16'h0010); view(2);
        // R4: in-full rules
        cur_req = "R4";  acc(1, 3, 0, 16'h0010); acc(1, 2, 1, 16'h0010);
        acc(1, 2, 1, 16'h0080); acc(1, 4, 0, 16'h0040); view(4);
        core(2'b10, 0, 0, 0); view(4);
        acc(1, 3, 0, 16'h0001); step(1, 1, 3, 0, 16'h0001, 2'b01, 0, 0, 0); view(3);
        core(2'b01, 0, 0, 0);
        // R5: post / empty rules
        cur_req = "R5";  core(0, 2'b01, 5, 0); acc(1, 4, 0, 16'h0002); view(5);
        acc(1, 5, 0, 16'h0002); core(0, 2'b01, 6, 0);
        step(1, 1, 6, 0, 16'h0002, 0, 2'b01, 6, 0); acc(1, 6, 0, 16'h0002);
        cur_req = "R8";  core(0, 2'b10, 5, 1); acc(1, 5, 0, 16'h0020); acc(1, 5, 1, 16'h0020);
        // R6: master force path
        cur_req = "R6";  core(0, 2'b11, 1, 0); acc(2, 3, 0, 16'h00AA); view(3);
        acc(2, 0, 0, 16'h0008); acc(2, 0, 0, 16'h0022); view(3);
        // R7: locked-out host ignored
        cur_req = "R7";  acc(3, 0, 0, 16'h2020); acc(1, 5, 0, 16'h0044); view(5);
        acc(1, 4, 0, 16'h0004); acc(2, 0, 0, 16'h0008);
        // R9: viewer sweep
        cur_req = "R9";  acc(1, 6, 0, 16'h0040);
        for (int h = 0; h < 8; h++) view(3'(h));
        // R10: random mixed traffic, both mailboxes
        cur_req = "R10";
        for (int n = 0; n < 4000; n++) begin
            bit [1:0] k;
            bit [15:0] d;
            k = 2'($urandom_range(0, 2));
            d = 16'($urandom);
            if ($urandom_range(0, 31) == 0) begin k = 3; d = d & 16'h2424; end
            step($urandom_range(0, 3) != 0, k, 3'($urandom), 1'($urandom), d,
                 ($urandom_range(0, 7) == 0) ? 2'($urandom) : 2'b00,
                 ($urandom_range(0, 7) == 0) ? 2'($urandom) : 2'b00,
                 3'($urandom), 1'($urandom));
        end
        done = 1'b1;
        summary();
        $finish;
    end
endmodule